// File: doc/BRIEF.md
# Rectifying Zero-Run Activation Compressor

This block sits at the output of a convolution tile engine. It takes a dense stream of signed accumulator sums for one channel tile, clamps negative sums to zero and caps large sums at the largest signed 16-bit value. It then turns the result into a sparse stream: one entry per non-zero activation, each carrying the value and a 4-bit count of the zeros skipped since the previous entry of the same tile. A zero run too long for the 4-bit field is split up with zero-valued filler entries. The entry stream goes to the writer of the compressed activation store. The input and the output each use a valid/ready handshake.

A tile holds `TILE_W*TILE_H` elements. Position is counted internally, and a flag on an element marks it as the first of a tile. The last non-zero entry of a tile cannot be known until the tile ends, so one entry is held back until then. That entry leaves with an end flag. If a tile is all zeros, a single empty marker leaves with the end flag instead.

The controller has five states:
- SCAN accepts input. It is the only state with `in_ready` high.
- HELD sends the held entry as a non-final entry.
- PAD sends filler entries while 16 or more zeros are pending.
- LAST sends the held entry with the end flag.
- EMPTY sends the empty marker.

Transitions:
- SCAN goes to HELD when a non-zero arrives and an entry is already held.
- SCAN goes to PAD when a non-zero arrives with no held entry and 16 or more pending zeros.
- SCAN goes to LAST at the end of a tile when an entry is held or has just been captured.
- SCAN goes to EMPTY when a tile ends with nothing held.
- HELD goes to PAD, to LAST or back to SCAN, according to the pending zeros and whether the tile has ended.
- PAD stays in PAD while 32 or more zeros are pending. Otherwise it goes to LAST or SCAN.
- LAST and EMPTY return to SCAN once their entry is taken.

Top module: `sparse_act_rle`

## Requirements
- R1: A negative input sum is treated as a zero activation. No entry ever carries a negative value (bit 15 of `out_value` is always 0).
- R2: A positive sum above 32767 is emitted as 32767. A sum in the range 1..32767 is emitted unchanged.
- R3: `out_gap` of a value entry equals the number of zero activations between it and the previous entry of the same tile, or since the tile start for the first entry.
- R4: When 16 or more zeros precede a non-zero activation, a filler entry with value 0 and gap 15 is emitted for each full group of 16. Each filler accounts for 15 skipped zeros plus itself. The value entry carries the remaining count (run mod 16).
- R5: Zeros after the last non-zero activation of a tile produce no entries. `out_last` is 1 on the final value entry of the tile and 0 on every other entry.
- R6: An all-zero tile produces exactly one entry: value 0, gap 0, `out_last` 1, `out_count` 0.
- R7: `out_count` numbers the entries of a tile from 1, with fillers included, so the final entry carries the tile total.
- R8: A tile is `TILE_W*TILE_H` accepted elements long. The zero run and the entry numbering restart at every tile boundary.
- R9: An element accepted with `in_first` high is position 0 of a new tile. Any unfinished tile's held entry and pending zeros are dropped.
- R10: While `out_valid` is high and `out_ready` low, all output fields hold steady. `in_ready` is low whenever an entry is waiting. Every entry is delivered exactly once, in order.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input element valid |
| in_ready | output | 1 | Block can take an element |
| in_data | input | IN_W (24) | Signed accumulator sum |
| in_first | input | 1 | Element starts a new tile |
| out_valid | output | 1 | Entry valid |
| out_ready | input | 1 | Consumer takes the entry |
| out_value | output | VAL_W (16) | Clamped activation, 0 for fillers and the empty marker |
| out_gap | output | GAP_W (4) | Zeros skipped before this entry |
| out_last | output | 1 | Final entry of the tile |
| out_count | output | clog2(TILE+1) (7) | 1-based entry number in the tile, 0 for the empty marker |

## Verification
The bench targets several boundaries:
- Runs of exactly 15 zeros, exactly 16, and more than 32. An off-by-one in the filler threshold would emit a gap-16 entry that wraps to 0, or an extra filler.
- Tiles whose only non-zero sits on the last element, and tiles that end in zeros. A wrong end decision would put the end flag on the wrong entry or emit trailing fillers.
- All-zero tiles, which expose a missing or duplicated empty marker.
- Saturation edges such as 32767, 32768, -1 and the most negative input, which catch a clamp that wraps.

An abandoned partial tile, together with a randomly throttled consumer, shows whether held entries leak across tiles or are lost or repeated under backpressure.

// File: rtl/sparse_act_pkg.sv
package sparse_act_pkg;

    typedef enum logic [2:0] {
        ST_SCAN  = 3'd0,
        ST_HELD  = 3'd1,
        ST_PAD   = 3'd2,
        ST_LAST  = 3'd3,
        ST_EMPTY = 3'd4
    } rle_state_e;

endpackage

// File: rtl/act_clamp.sv
module act_clamp #(
    parameter int IN_W  = 24,
    parameter int VAL_W = 16
) (
    input  logic [IN_W-1:0]  din,
    output logic [VAL_W-1:0] dout,
    output logic             is_zero
);

    generate
        if (IN_W >= VAL_W) begin : g_sat
            localparam logic [IN_W-1:0] LIM = IN_W'((1 << (VAL_W - 1)) - 1);
            always_comb begin
                if (din[IN_W-1]) begin
                    dout = '0;
                end else if (din > LIM) begin
                    dout = VAL_W'(LIM);
                end else begin
                    dout = din[VAL_W-1:0];
                end
            end
        end else begin : g_wide
            always_comb begin
                dout = din[IN_W-1] ? '0 : VAL_W'(din);
            end
        end
    endgenerate

    assign is_zero = (dout == '0);

endmodule

// File: rtl/tile_pos.sv
module tile_pos #(
    parameter int TILE = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic first,
    output logic is_end
);

    localparam int PW = (TILE > 1) ? $clog2(TILE) : 1;
    localparam logic [PW-1:0] LAST_POS = PW'(TILE - 1);

    logic [PW-1:0] pos;
    logic [PW-1:0] eff_pos;

    assign eff_pos = first ? '0 : pos;
    assign is_end  = (eff_pos == LAST_POS);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (adv) begin
            pos <= is_end ? '0 : PW'(eff_pos + 1'b1);
        end
    end

endmodule

// File: rtl/sparse_act_rle.sv
module sparse_act_rle
    import sparse_act_pkg::*;
#(
    parameter int TILE_W = 8,
    parameter int TILE_H = 8,
    parameter int IN_W   = 24,
    parameter int VAL_W  = 16,
    parameter int GAP_W  = 4,
    localparam int TILE  = TILE_W * TILE_H,
    localparam int CW    = $clog2(TILE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IN_W-1:0]  in_data,
    input  logic             in_first,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [VAL_W-1:0] out_value,
    output logic [GAP_W-1:0] out_gap,
    output logic             out_last,
    output logic [CW-1:0]    out_count
);

    localparam int unsigned PAD_RUN = 1 << GAP_W;
    localparam int unsigned PAD_TWO = 2 * PAD_RUN;

    rle_state_e state, state_n;

    logic [CW-1:0]    zrun;
    logic             hold_vld;
    logic [VAL_W-1:0] hold_val;
    logic [GAP_W-1:0] hold_gap;
    logic [VAL_W-1:0] new_val;
    logic             new_end;
    logic [CW-1:0]    ent_cnt;

    logic [VAL_W-1:0] cl_val;
    logic             cl_zero;
    logic             pos_end;
    logic             acc;
    logic             fire;

    logic [CW-1:0]    base_z;
    logic             base_h;
    logic [CW-1:0]    base_c;
    logic             base_long;
    logic             zrun_long;
    logic             zrun_two;
    logic [CW-1:0]    zrun_less;

    act_clamp #(
        .IN_W (IN_W),
        .VAL_W(VAL_W)
    ) clamp_i (
        .din    (in_data),
        .dout   (cl_val),
        .is_zero(cl_zero)
    );

    tile_pos #(
        .TILE(TILE)
    ) pos_i (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (acc),
        .first (in_first),
        .is_end(pos_end)
    );

    assign acc  = in_valid && (state == ST_SCAN);
    assign fire = out_valid && out_ready;

    // A tile start wipes the running tile state before the element is used
    assign base_z    = in_first ? '0 : zrun;
    assign base_h    = !in_first && hold_vld;
    assign base_c    = in_first ? '0 : ent_cnt;
    assign base_long = (32'(base_z) >= PAD_RUN);
    assign zrun_long = (32'(zrun) >= PAD_RUN);
    assign zrun_two  = (32'(zrun) >= PAD_TWO);
    assign zrun_less = CW'(32'(zrun) - PAD_RUN);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_SCAN;
        end else begin
            state <= state_n;
        end
    end

    // Next-state decision
    always_comb begin
        state_n = state;
        unique case (state)
            ST_SCAN: begin
                if (acc) begin
                    if (cl_zero) begin
                        if (pos_end) begin
                            state_n = base_h ? ST_LAST : ST_EMPTY;
                        end
                    end else if (base_h) begin
                        state_n = ST_HELD;
                    end else if (base_long) begin
                        state_n = ST_PAD;
                    end else begin
                        state_n = pos_end ? ST_LAST : ST_SCAN;
                    end
                end
            end
            ST_HELD: begin
                if (fire) begin
                    if (zrun_long) begin
                        state_n = ST_PAD;
                    end else begin
                        state_n = new_end ? ST_LAST : ST_SCAN;
                    end
                end
            end
            ST_PAD: begin
                if (fire && !zrun_two) begin
                    state_n = new_end ? ST_LAST : ST_SCAN;
                end
            end
            ST_LAST, ST_EMPTY: begin
                if (fire) begin
                    state_n = ST_SCAN;
                end
            end
            default: state_n = ST_SCAN;
        endcase
    end

    // Output decode
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_value = '0;
        out_gap   = '0;
        out_last  = 1'b0;
        out_count = '0;
        unique case (state)
            ST_SCAN: begin
                in_ready = 1'b1;
            end
            ST_HELD: begin
                out_valid = 1'b1;
                out_value = hold_val;
                out_gap   = hold_gap;
                out_count = CW'(ent_cnt + 1'b1);
            end
            ST_PAD: begin
                out_valid = 1'b1;
                out_gap   = '1;
                out_count = CW'(ent_cnt + 1'b1);
            end
            ST_LAST: begin
                out_valid = 1'b1;
                out_value = hold_val;
                out_gap   = hold_gap;
                out_last  = 1'b1;
                out_count = CW'(ent_cnt + 1'b1);
            end
            ST_EMPTY: begin
                out_valid = 1'b1;
                out_last  = 1'b1;
            end
            default: begin
                in_ready = 1'b0;
            end
        endcase
    end

    // Tile datapath: pending zeros, held entry, entry numbering
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zrun     <= '0;
            hold_vld <= 1'b0;
            hold_val <= '0;
            hold_gap <= '0;
            new_val  <= '0;
            new_end  <= 1'b0;
            ent_cnt  <= '0;
        end else begin
            case (state)
                ST_SCAN: begin
                    if (acc) begin
                        ent_cnt <= base_c;
                        if (cl_zero) begin
                            zrun     <= CW'(base_z + 1'b1);
                            hold_vld <= base_h;
                        end else begin
                            new_val <= cl_val;
                            new_end <= pos_end;
                            if (base_h || base_long) begin
                                zrun     <= base_z;
                                hold_vld <= base_h;
                            end else begin
                                hold_vld <= 1'b1;
                                hold_val <= cl_val;
                                hold_gap <= GAP_W'(base_z);
                                zrun     <= '0;
                            end
                        end
                    end
                end
                ST_HELD: begin
                    if (fire) begin
                        ent_cnt <= CW'(ent_cnt + 1'b1);
                        if (zrun_long) begin
                            hold_vld <= 1'b0;
                        end else begin
                            hold_vld <= 1'b1;
                            hold_val <= new_val;
                            hold_gap <= GAP_W'(zrun);
                            zrun     <= '0;
                        end
                    end
                end
                ST_PAD: begin
                    if (fire) begin
                        ent_cnt <= CW'(ent_cnt + 1'b1);
                        if (zrun_two) begin
                            zrun <= zrun_less;
                        end else begin
                            hold_vld <= 1'b1;
                            hold_val <= new_val;
                            hold_gap <= GAP_W'(zrun_less);
                            zrun     <= '0;
                        end
                    end
                end
                ST_LAST, ST_EMPTY: begin
                    if (fire) begin
                        hold_vld <= 1'b0;
                        zrun     <= '0;
                        ent_cnt  <= '0;
                    end
                end
                default: begin
                    hold_vld <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/sparse_act_rle_chk.sv
module sparse_act_rle_chk #(
    parameter int VAL_W = 16,
    parameter int GAP_W = 4,
    parameter int CW    = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_valid,
    input logic             out_ready,
    input logic [VAL_W-1:0] out_value,
    input logic [GAP_W-1:0] out_gap,
    input logic             out_last,
    input logic [CW-1:0]    out_count
);

    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_value) && $stable(out_gap)
                                    && $stable(out_last) && $stable(out_count));

    a_r1_non_negative: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !out_value[VAL_W-1]);

    a_r4_filler_form: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_value == '0) && !out_last |-> (out_gap == '1));

    a_r6_empty_form: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_last && (out_count == '0) |-> (out_value == '0) && (out_gap == '0));

    a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !out_last |=> !out_valid || (out_count == CW'($past(out_count) + 1'b1)));

endmodule

bind sparse_act_rle sparse_act_rle_chk #(
    .VAL_W(VAL_W),
    .GAP_W(GAP_W),
    .CW   (CW)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_value(out_value),
    .out_gap  (out_gap),
    .out_last (out_last),
    .out_count(out_count)
);

// File: tb/sparse_act_rle_tb_top.sv
module sparse_act_rle_tb_top;

    localparam int TILE = 64;
    localparam int CW   = 7;

    typedef struct packed {
        logic [15:0]   v;
        logic [3:0]    g;
        logic          l;
        logic [CW-1:0] c;
    } ent_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [23:0]   in_data = '0;
    logic          in_first = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [15:0]   out_value;
    logic [3:0]    out_gap;
    logic          out_last;
    logic [CW-1:0] out_count;

    int total = 0;
    int bad = 0;
    int ready_pct = 100;
    ent_t exp_q[$];

    // bench model state
    int          m_zrun = 0;
    bit          m_hold = 0;
    logic [15:0] m_hval = '0;
    int          m_hgap = 0;
    int          m_cnt = 0;
    int          m_pos = 0;

    logic [23:0] blk [TILE];

    always #5 clk = ~clk;

    sparse_act_rle dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .in_first (in_first),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .out_value(out_value),
        .out_gap  (out_gap),
        .out_last (out_last),
        .out_count(out_count)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // R1/R2 reference clamp
    function automatic logic [15:0] ref_clamp(input logic [23:0] x);
        if (x[23]) return 16'd0;
        if (x > 24'd32767) return 16'h7FFF;
        return x[15:0];
    endfunction

    function automatic void push_ent(input logic [15:0] v, input int g,
                                     input bit l, input int c);
        ent_t e;
        e.v = v; e.g = 4'(g); e.l = l; e.c = CW'(c);
        exp_q.push_back(e);
    endfunction

    // Spec-level model: R3 R4 R5 R6 R7 R8 R9
    function automatic void model_elem(input logic [23:0] d, input bit f);
        logic [15:0] r;
        bit fin;
        if (f) begin
            m_zrun = 0; m_hold = 0; m_cnt = 0; m_pos = 0;
        end
        r = ref_clamp(d);
        fin = (m_pos == TILE - 1);
        if (r == 16'd0) begin
            m_zrun++;
        end else begin
            if (m_hold) begin
                m_cnt++;
                push_ent(m_hval, m_hgap, 1'b0, m_cnt);
            end
            while (m_zrun >= 16) begin
                m_cnt++;
                push_ent(16'd0, 15, 1'b0, m_cnt);
                m_zrun -= 16;
            end
            m_hold = 1; m_hval = r; m_hgap = m_zrun; m_zrun = 0;
        end
        if (fin) begin
            if (m_hold) begin
                m_cnt++;
                push_ent(m_hval, m_hgap, 1'b1, m_cnt);
            end else begin
                push_ent(16'd0, 0, 1'b1, 0);
            end
            m_zrun = 0; m_hold = 0; m_cnt = 0; m_pos = 0;
        end else begin
            m_pos++;
        end
    endfunction

    task automatic send_elem(input logic [23:0] d, input bit f);
        in_valid = 1'b1;
        in_data  = d;
        in_first = f;
        model_elem(d, f);
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_first = 1'b0;
        if ($urandom_range(0, 3) == 0) @(negedge clk);
    endtask

    task automatic send_blk();
        for (int i = 0; i < TILE; i++) send_elem(blk[i], i == 0);
    endtask

    task automatic clear_blk();
        for (int i = 0; i < TILE; i++) blk[i] = '0;
    endtask

    task automatic rand_blk(input int kind);
        for (int i = 0; i < TILE; i++) begin
            int p;
            p = $urandom_range(0, 99);
            case (kind)
                0: blk[i] = (p < 10) ? 24'($urandom_range(1, 500)) : 24'd0;
                1: blk[i] = (p < 70) ? 24'($urandom_range(1, 30000)) : 24'd0;
                2: blk[i] = (p < 50) ? 24'(-$urandom_range(1, 9000)) : 24'd0;
                default: blk[i] = (p < 30) ? 24'($urandom) : 24'd0;
            endcase
        end
    endtask

    // Consumer and output monitor
    initial begin
        bit          stall = 0;
        logic [15:0] s_v;
        logic [3:0]  s_g;
        logic        s_l;
        logic [CW-1:0] s_c;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (stall) begin
                    // R10: stalled entry must hold
                    check(out_valid && out_value == s_v && out_gap == s_g &&
                          out_last == s_l && out_count == s_c,
                          "R10", "stalled entry changed", int'(out_value), int'(s_v));
                end
                out_ready = ($urandom_range(0, 99) < ready_pct);
                stall = 0;
                if (out_valid && out_ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R10", "unexpected entry", int'(out_value), -1);
                    end else begin
                        ent_t e;
                        e = exp_q.pop_front();
                        check(out_value == e.v, "R1/R2", "value", int'(out_value), int'(e.v));
                        check(out_gap == e.g, "R3/R4", "gap", int'(out_gap), int'(e.g));
                        check(out_last == e.l, "R5/R6", "last", int'(out_last), int'(e.l));
                        check(out_count == e.c, "R7", "count", int'(out_count), int'(e.c));
                    end
                end else if (out_valid) begin
                    stall = 1;
                    s_v = out_value; s_g = out_gap; s_l = out_last; s_c = out_count;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R10 watchdog expired actual=%0d expected=0", exp_q.size());
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        check(out_valid == 1'b0, "R11", "out_valid after reset", int'(out_valid), 0);
        check(in_ready == 1'b1, "R11", "in_ready after reset", int'(in_ready), 1);
        @(negedge clk);

        // R6 all-zero tile
        clear_blk(); send_blk();
        // R4 40 zeros then a value: two fillers, gap 8; R5 trailing zeros dropped
        clear_blk(); blk[40] = 24'd5; send_blk();
        // R3 exactly 15 zeros, then exactly 16 zeros (filler then gap 0)
        clear_blk(); blk[15] = 24'd77; blk[32] = 24'd9; send_blk();
        // R5 only the final element non-zero: 63 zeros -> three fillers, gap 15
        clear_blk(); blk[TILE-1] = 24'd1234; send_blk();
        // R1/R2 saturation edges
        clear_blk();
        blk[0] = 24'h7FFFFF; blk[1] = 24'd32768; blk[2] = 24'd32767;
        blk[3] = 24'hFFFFFF; blk[4] = 24'h800000; blk[5] = 24'd1;
        send_blk();
        // R9 abandoned partial tile followed by a fresh tile
        for (int i = 0; i < 10; i++)
            send_elem((i == 2) ? 24'd11 : (i == 5) ? 24'd22 : 24'd0, i == 0);
        clear_blk(); blk[3] = 24'd33; send_blk();

        // R8 random tiles under varied backpressure
        for (int b = 0; b < 36; b++) begin
            ready_pct = (b % 3 == 0) ? 100 : (b % 3 == 1) ? 50 : 20;
            rand_blk(b % 4);
            send_blk();
        end

        ready_pct = 100;
        for (int w = 0; w < 3000 && exp_q.size() != 0; w++) @(negedge clk);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R10", "entries missing", exp_q.size(), 0);
        check(in_ready == 1'b1 && out_valid == 1'b0, "R10", "idle at end",
              int'(out_valid), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule